// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Change-Pending Flag

The block turns a free-running clock into a periodic single-cycle enable pulse whose period is a programmable whole number of input cycles. One control register holds three things: the ratio, a run bit, and a read-only flag that reports a pending ratio change. Downstream logic qualifies its registers with the pulse instead of using a derived clock. This keeps the pulse train free of runt or stretched periods when the ratio changes.

A ratio written while the divider runs is held aside. It is applied only when the current output period ends, and the flag stays set until then. Software polls the flag to learn when the new rate is in force. A write that stops the divider, or any write made while it is stopped, takes effect at once and never sets the flag.

Top module: `clkdiv_busy`

## Requirements
- R1: After reset, `clk_en_o` is 0 and `reg_rdata_o` reads all zeros.
- R2: With the run bit (bit 31) set and the ratio field (bits 7:0) holding N ≥ 1, `clk_en_o` is high for exactly one cycle out of every N.
- R3: A ratio field of 0 behaves as a ratio of 1, so the pulse is high on every cycle.
- R4: A write with the run bit set, made while the divider already runs, sets the pending flag (bit 28) in the cycle after the write. The old ratio stays in force until its current period ends.
- R5: The staged ratio takes over on the cycle after the last pulse of the old period. The pending flag clears on that same cycle, and counting restarts from the first cycle of the new period.
- R6: A write made while the divider is stopped loads the ratio at once and leaves the pending flag at 0.
- R7: The value written to bit 28 has no effect. The flag changes only as R4, R5, R6 and R9 describe.
- R8: A second running write made while a change is pending replaces the staged ratio, and the pending flag stays 1.
- R9: While the run bit is 0, `clk_en_o` stays 0. After a write that starts the divider with ratio N, the first pulse comes on the Nth cycle after the write edge.
- R10: Reads return the last written ratio field in bits 7:0, the flag in bit 28 and the run bit in bit 31. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read data |
| clk_en_o | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
Two situations are hard to reach from the ports. One is a write that lands exactly on the boundary cycle of a period. The other is a second write arriving while a change is still staged. The bench drives back-to-back writes on consecutive cycles to hit the replacement case on purpose. It then follows with a long stream of randomly spaced writes at small ratios, so that writes keep colliding with period boundaries. A cycle-level reference model in the bench checks both the pulse and the read value on every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    WR_IDLE,
    WR_STAGE,
    WR_APPLY
  } wr_kind_e;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int DIV_LSB  = 0,
  parameter int DIV_W    = 8,
  parameter int BUSY_POS = 28,
  parameter int EN_POS   = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             period_end_i,
  output logic             en_o,
  output logic [DIV_W-1:0] active_o,
  output logic [DIV_W-1:0] raw_o,
  output logic             busy_o,
  output logic             load_now_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] wr_div, wr_ratio;
  logic             wr_en;
  wr_kind_e         kind;

  logic             en_q, busy_q;
  logic [DIV_W-1:0] active_q, pend_q, raw_q;

  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  assign wr_div   = wdata_i[DIV_LSB +: DIV_W];
  assign wr_en    = wdata_i[EN_POS];
  assign wr_ratio = (wr_div == '0) ? ONE : wr_div;

  always_comb begin
    kind = WR_IDLE;
    if (we_i) kind = (en_q && wr_en) ? WR_STAGE : WR_APPLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
      active_q <= ONE;
      pend_q   <= ONE;
      raw_q    <= '0;
    end else begin
      unique case (kind)
        WR_STAGE: begin
          raw_q  <= wr_div;
          pend_q <= wr_ratio;
          busy_q <= 1'b1;
        end
        WR_APPLY: begin
          raw_q    <= wr_div;
          en_q     <= wr_en;
          active_q <= wr_ratio;
          pend_q   <= wr_ratio;
          busy_q   <= 1'b0;
        end
        default: begin
          if (period_end_i && busy_q) begin
            active_q <= pend_q;
            busy_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  assign en_o       = en_q;
  assign active_o   = active_q;
  assign raw_o      = raw_q;
  assign busy_o     = busy_q;
  assign load_now_o = (kind == WR_APPLY);

  assert_busy_needs_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> en_q);
  assert_busy_rise_running_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(en_q));
  assert_ratio_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q != '0);
  assert_rewrite_keeps_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && we_i && wr_en) |=> busy_q);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             period_end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last         = (cnt_q == ratio_i - DIV_W'(1));
  assign period_end_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else if (last)               cnt_q <= '0;
    else                         cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < ratio_i));
  assert_idle_cnt_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_busy.sv
module clkdiv_busy #(
  parameter int REG_W    = 32,
  parameter int DIV_LSB  = 0,
  parameter int DIV_W    = 8,
  parameter int BUSY_POS = 28,
  parameter int EN_POS   = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             clk_en_o
);
  logic             en, busy, load_now, period_end;
  logic [DIV_W-1:0] active, raw;

  clkdiv_regs #(
    .REG_W(REG_W), .DIV_LSB(DIV_LSB), .DIV_W(DIV_W),
    .BUSY_POS(BUSY_POS), .EN_POS(EN_POS)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .wdata_i      (reg_wdata_i),
    .period_end_i (period_end),
    .en_o         (en),
    .active_o     (active),
    .raw_o        (raw),
    .busy_o       (busy),
    .load_now_o   (load_now)
  );

  clkdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .restart_i    (load_now),
    .ratio_i      (active),
    .period_end_o (period_end)
  );

  always_comb begin
    reg_rdata_o                     = '0;
    reg_rdata_o[DIV_LSB +: DIV_W]   = raw;
    reg_rdata_o[BUSY_POS]           = busy;
    reg_rdata_o[EN_POS]             = en;
  end

  assign clk_en_o = period_end;

  // Staged ratio lands at the boundary and the flag drops with it.
  assert_busy_clears_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && period_end && !reg_we_i) |=> !busy);
  assert_ratio_holds_mid_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !period_end && !(reg_we_i && !reg_wdata_i[EN_POS])) |=> $stable(active));
  assert_idle_write_no_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !en) |=> !busy);
  assert_stopped_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !clk_en_o);
endmodule

// File: tb/tb_clkdiv_busy.sv
`timescale 1ns/1ps
module tb_clkdiv_busy;
  localparam logic [31:0] RUN  = 32'h8000_0000;
  localparam logic [31:0] FLAG = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_en;

  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit       m_en, m_busy;
  int       m_act, m_pend, m_cnt;
  bit [7:0] m_raw;

  always #2 clk = ~clk;

  clkdiv_busy dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .clk_en_o(clk_en)
  );

  function automatic int ratio_of(bit [7:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  function automatic bit exp_pulse();
    return m_en && (m_cnt == m_act - 1);
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = '0;
    r[7:0] = m_raw;
    r[28]  = m_busy;
    r[31]  = m_en;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_act = 1; m_pend = 1; m_cnt = 0; m_raw = 0;
    end else begin
      bit pend_end;
      pend_end = exp_pulse();
      if (we) begin
        m_raw = wdata[7:0];
        if (m_en && wdata[31]) begin
          m_pend = ratio_of(wdata[7:0]);
          m_busy = 1;
          m_cnt  = pend_end ? 0 : m_cnt + 1;
        end else begin
          m_en = wdata[31];
          m_act = ratio_of(wdata[7:0]);
          m_pend = m_act;
          m_busy = 0;
          m_cnt = 0;
        end
      end else if (pend_end) begin
        m_cnt = 0;
        if (m_busy) begin
          m_act = m_pend;
          m_busy = 0;
        end
      end else if (m_en) begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk(clk_en === exp_pulse(), cur_req, "pulse", 32'(clk_en), 32'(exp_pulse()));
      chk(rdata === exp_rdata(), cur_req, "readback", rdata, exp_rdata());
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1;
    wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      if (clk_en) c++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (rdata[28] && guard < 300) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int c;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdata === 32'h0, "R1", "reset readback", rdata, 32'h0);
    chk(clk_en === 1'b0, "R1", "reset pulse", 32'(clk_en), 32'h0);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R2, R10: ratio 5
    cur_req = "R2";
    wr(RUN | 32'd5);
    chk(rdata === 32'h8000_0005, "R10", "readback", rdata, 32'h8000_0005);
    count_pulses(40, c);
    chk(c == 8, "R2", "pulses in 40 at ratio 5", 32'(c), 32'd8);

    // R4, R5, R3: running change to ratio 0
    cur_req = "R4";
    wr(RUN | 32'd0);
    chk(rdata[28] === 1'b1, "R4", "flag after running write", 32'(rdata[28]), 32'h1);
    cur_req = "R5";
    wait_idle();
    chk(clk_en === 1'b1, "R5", "new ratio at flag clear", 32'(clk_en), 32'h1);
    cur_req = "R3";
    count_pulses(10, c);
    chk(c == 10, "R3", "pulses in 10 at ratio 0", 32'(c), 32'd10);

    // R8: back-to-back running writes
    cur_req = "R8";
    wr(RUN | 32'd9);
    wait_idle();
    repeat (4) @(negedge clk);
    we = 1'b1; wdata = RUN | 32'd7;
    @(negedge clk);
    wdata = RUN | 32'd3;
    @(negedge clk);
    we = 1'b0;
    chk(rdata[28] === 1'b1, "R8", "flag after second write", 32'(rdata[28]), 32'h1);
    chk(rdata[7:0] === 8'd3, "R8", "replaced field", 32'(rdata[7:0]), 32'd3);
    wait_idle();
    count_pulses(30, c);
    chk(c == 10, "R8", "pulses in 30 at replacement ratio 3", 32'(c), 32'd10);

    // R7, R9, R6: stopped writes with the flag bit set
    cur_req = "R7";
    wr(FLAG | 32'd4);
    chk(rdata === 32'h0000_0004, "R7", "flag bit write ignored", rdata, 32'h0000_0004);
    cur_req = "R9";
    count_pulses(10, c);
    chk(c == 0, "R9", "no pulses while stopped", 32'(c), 32'd0);
    cur_req = "R6";
    wr(RUN | FLAG | 32'd4);
    chk(rdata === 32'h8000_0004, "R6", "start write leaves flag clear", rdata, 32'h8000_0004);
    count_pulses(3, c);
    chk(c == 0, "R9", "no early pulse after start", 32'(c), 32'd0);
    chk(clk_en === 1'b1, "R9", "first pulse on 4th cycle", 32'(clk_en), 32'h1);

    // random writes, including collisions with period ends
    cur_req = "R2";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom & 32'h0fff_ff00;
      d[7:0] = 8'($urandom_range(0, 12));
      d[28] = 1'($urandom);
      d[31] = ($urandom_range(0, 3) != 0);
      wr(d);
      repeat ($urandom_range(0, 30)) @(negedge clk);
    end
    cur_req = "R10";
    wr(32'h0fff_ff0b);
    chk(rdata === 32'h0000_000b, "R10", "unused bits read 0", rdata, 32'h0000_000b);
    finish_run();
  end
endmodule